// File: doc/BRIEF.md
# Binary16 Fused Multiply-Add Pipeline

This block computes `d = round(±(a·b) ± c)` on IEEE-754 binary16 operands with a single rounding step. It takes one operation per cycle and returns one result per cycle three clock edges later. Each result comes with five exception flags. A 3-bit op-class select routes every operation through the same shared datapath: add, multiply, multiply-add, multiply-subtract, a quiet multiply-add that reports no flags, and a residual `1 − a·b` for iterative refinement. A per-lane predicate keeps the old addend when it is false.

The first stage unpacks the operands, applies the op-class substitutions, multiplies the significands exactly and classifies special values. The second stage places the exact product and the addend in one wide fixed-point frame and adds them. The third stage finds the leading one, rounds under the 2-bit mode captured with the operands, and packs the result and the flags. Subnormal inputs and outputs are handled in full and are never flushed to zero.

Top module: `fma16_pipe`

## Requirements
- R1: A `valid_i` accepted at a rising edge gives `valid_o` high with its `d_o`/`flags_o` after the second following rising edge. That is three registers, and results keep their issue order. After reset, `valid_o`, `d_o` and `flags_o` are zero.
- R2: The exact product is added to the addend with no intermediate rounding. For example, a = b = 0x3C01 and c = 0xBC02 give 0x0010 with no flags.
- R3: Rounding mode `rm_i` is 0 for nearest-even, 1 for toward zero, 2 for toward +inf and 3 for toward −inf. It is captured with the operands. 1.0 + 2^-11 gives 0x3C01 only under mode 2 and gives 0x3C00 under the other three.
- R4: `op_i` selects the operation. 0 is a + c (b ignored), 1 is a·b (c ignored), 2 is a·b + c, 3 is a·b − c, 4 is quiet a·b + c, and 5 is 1 − a·b. Codes 6 and 7 act as 2.
- R5: In residual mode the addend is forced to 1.0 and the product is negated, so 0.5·0.5 gives 0x3A00.
- R6: Any NaN result is the quiet NaN 0x7E00. Invalid is set for inf − inf, for inf·0, and for a signalling NaN input. A quiet NaN input alone sets no flag.
- R7: On overflow, overflow and inexact are both set. The result is infinity under nearest-even and under the directed mode that points the same way as the sign. It is 0x7BFF (signed) under toward-zero and under the directed mode that points the other way.
- R8: An inexact result sets the inexact flag. 1.0 + 2^-24 gives 0x3C00 with only inexact set.
- R9: Underflow is set when the rounded result is subnormal or zero and inexact. Subnormal operands and results are exact where representable.
- R10: Op class 4 drives all five flags to zero, and its value is unchanged.
- R11: With `pred_i` low, the result is the raw `c_i` that entered with the operation, and the flags are zero.
- R12: `flags_o` bit 4 is invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow and bit 0 inexact. Divide-by-zero is always zero because no operation divides.
- R13: An exact zero sum keeps the common sign when both terms share it. Otherwise it is +0, or −0 under mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| a_i | input | 16 | Multiplicand a (binary16) |
| b_i | input | 16 | Multiplier b (binary16) |
| c_i | input | 16 | Addend c (binary16), also the predicate-false result |
| rm_i | input | 2 | Rounding mode |
| op_i | input | 3 | Op-class select |
| pred_i | input | 1 | Lane predicate |
| valid_o | output | 1 | Result present |
| d_o | output | 16 | Rounded result (binary16) |
| flags_o | output | 5 | Exception flags {invalid, div-zero, overflow, underflow, inexact} |

## Verification
The assertions assume that every cycle carries defined operand, mode and op-class values, whether `valid_i` is high or low. The datapath registers every stage each cycle, and the output checks refer back to the previous stage's predicate and op class. The stimulus therefore always drives known values and drops only `valid_i` between operations. The random stream draws op codes from 0 to 5 and mixes in specials, subnormals and values near the largest finite number. This keeps the overflow and underflow properties exercised in the cases they are meant to cover.

// File: rtl/fma16_pkg.sv
package fma16_pkg;
  localparam int EXP_W   = 5;
  localparam int MAN_W   = 10;
  localparam int H_W     = 1 + EXP_W + MAN_W;
  localparam int SIG_W   = MAN_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX_N  = (1 << EXP_W) - 2;
  localparam int SUB_LSB = BIAS + MAN_W - 1;           // frame position of the smallest subnormal
  localparam int FIX_W   = 2 * EMAX_N + 2 * SIG_W;     // exact product + addend + carry
  localparam int SH_W    = 7;
  localparam int ENC_W   = H_W + 1;
  localparam int FLG_W   = 5;

  localparam logic [H_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [H_W-1:0] ONE_H   = {1'b0, EXP_W'(BIAS), {MAN_W{1'b0}}};
  localparam logic [H_W-1:0] QNAN_H  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_MUL = 3'd1, OP_MADD = 3'd2,
    OP_MSUB = 3'd3, OP_MADDQ = 3'd4, OP_RESID = 3'd5
  } op_e;

  typedef enum logic [1:0] {RM_RNE = 2'd0, RM_RTZ = 2'd1, RM_RUP = 2'd2, RM_RDN = 2'd3} rm_e;

  typedef struct packed {
    logic             sign;
    logic [SIG_W-1:0] sig;
    logic [EXP_W-1:0] eeff;
    logic             inf;
    logic             nan;
    logic             snan;
    logic             zero;
  } unp_t;

  typedef struct packed {
    logic               valid;
    logic               pred;
    logic               quiet;
    logic [1:0]         rm;
    logic [H_W-1:0]     c_raw;
    logic               sp;
    logic               sc;
    logic [2*SIG_W-1:0] prod;
    logic [SH_W-1:0]    pshift;
    logic [SIG_W-1:0]   csig;
    logic [SH_W-1:0]    cshift;
    logic               res_nan;
    logic               res_inf;
    logic               inf_sign;
    logic               invalid;
  } s1_t;

  typedef struct packed {
    logic             valid;
    logic             pred;
    logic             quiet;
    logic [1:0]       rm;
    logic [H_W-1:0]   c_raw;
    logic             sign;
    logic [FIX_W-1:0] mag;
    logic             res_nan;
    logic             res_inf;
    logic             inf_sign;
    logic             invalid;
  } s2_t;

  function automatic unp_t unpack(input logic [H_W-1:0] x);
    unp_t u;
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] f;
    e = x[H_W-2:MAN_W];
    f = x[MAN_W-1:0];
    u.sign = x[H_W-1];
    u.sig  = {(e != '0), f};
    u.eeff = (e != '0) ? e : EXP_W'(1);
    u.inf  = (e == '1) && (f == '0);
    u.nan  = (e == '1) && (f != '0);
    u.snan = u.nan && !f[MAN_W-1];
    u.zero = (e == '0) && (f == '0);
    return u;
  endfunction
endpackage

// File: rtl/fma16_mul_stage.sv
module fma16_mul_stage
  import fma16_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [H_W-1:0] a_i,
  input  logic [H_W-1:0] b_i,
  input  logic [H_W-1:0] c_i,
  input  logic [1:0]     rm_i,
  input  logic [2:0]     op_i,
  input  logic           pred_i,
  output s1_t            s1_o
);
  logic [H_W-1:0] b_eff, c_eff;
  unp_t ua, ub, uc;
  logic sp, any_nan, any_snan, mul_inv, p_inf, add_inv;
  s1_t nxt;

  always_comb begin
    b_eff = (op_i == OP_ADD) ? ONE_H : b_i;
    ua = unpack(a_i);
    ub = unpack(b_eff);
    sp = ua.sign ^ ub.sign ^ (op_i == OP_RESID);
    case (op_i)
      OP_MUL:   c_eff = {sp, {(H_W-1){1'b0}}};       // signed zero keeps product sign
      OP_RESID: c_eff = ONE_H;
      OP_MSUB:  c_eff = {~c_i[H_W-1], c_i[H_W-2:0]};
      default:  c_eff = c_i;
    endcase
    uc = unpack(c_eff);

    any_nan  = ua.nan | ub.nan | uc.nan;
    any_snan = ua.snan | ub.snan | uc.snan;
    mul_inv  = (ua.inf & ub.zero) | (ua.zero & ub.inf);
    p_inf    = ua.inf | ub.inf;
    add_inv  = p_inf & !mul_inv & uc.inf & (sp != uc.sign);

    nxt.valid    = valid_i;
    nxt.pred     = pred_i;
    nxt.quiet    = (op_i == OP_MADDQ);
    nxt.rm       = rm_i;
    nxt.c_raw    = c_i;
    nxt.sp       = sp;
    nxt.sc       = uc.sign;
    nxt.prod     = (2*SIG_W)'(ua.sig) * (2*SIG_W)'(ub.sig);
    nxt.pshift   = SH_W'(ua.eeff) + SH_W'(ub.eeff) - SH_W'(2);
    nxt.csig     = uc.zero ? '0 : uc.sig;
    nxt.cshift   = SH_W'(uc.eeff) + SH_W'(SUB_LSB - 1);
    nxt.res_nan  = any_nan | mul_inv | add_inv;
    nxt.invalid  = any_snan | (!any_nan & (mul_inv | add_inv));
    nxt.res_inf  = !nxt.res_nan & (p_inf | uc.inf);
    nxt.inf_sign = p_inf ? sp : uc.sign;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_o <= '0;
    else         s1_o <= nxt;
  end

  // R5: residual forces the addend to +1.0 regardless of c_i
  p_resid_addend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RESID) |=> (!s1_o.sc && s1_o.cshift == SH_W'(BIAS + SUB_LSB - 1)));
endmodule

// File: rtl/fma16_add_stage.sv
module fma16_add_stage
  import fma16_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  s1_t  s1_i,
  output s2_t  s2_o
);
  logic [FIX_W-1:0] pa, ca;
  s2_t nxt;

  always_comb begin
    pa = FIX_W'(s1_i.prod) << s1_i.pshift;
    ca = FIX_W'(s1_i.csig) << s1_i.cshift;
    nxt.valid    = s1_i.valid;
    nxt.pred     = s1_i.pred;
    nxt.quiet    = s1_i.quiet;
    nxt.rm       = s1_i.rm;
    nxt.c_raw    = s1_i.c_raw;
    nxt.res_nan  = s1_i.res_nan;
    nxt.res_inf  = s1_i.res_inf;
    nxt.inf_sign = s1_i.inf_sign;
    nxt.invalid  = s1_i.invalid;
    if (s1_i.sp == s1_i.sc) begin
      nxt.mag  = pa + ca;
      nxt.sign = s1_i.sp;
    end else if (pa >= ca) begin
      nxt.mag  = pa - ca;
      nxt.sign = s1_i.sp;
    end else begin
      nxt.mag  = ca - pa;
      nxt.sign = s1_i.sc;
    end
    if (nxt.mag == '0 && s1_i.sp != s1_i.sc) nxt.sign = (s1_i.rm == RM_RDN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s2_o <= '0;
    else         s2_o <= nxt;
  end

  // R13: cancellation of opposite-signed terms yields -0 only in round-down
  p_zero_sign_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_i.sp != s1_i.sc && s1_i.prod != '0 && s1_i.csig != '0)
      |=> (s2_o.mag != '0 || s2_o.sign == (s2_o.rm == RM_RDN)));
endmodule

// File: rtl/fma16_round_stage.sv
module fma16_round_stage
  import fma16_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  s2_t              s2_i,
  output logic             valid_o,
  output logic [H_W-1:0]   d_o,
  output logic [FLG_W-1:0] flags_o
);
  int unsigned       msb, lsb;
  logic [MAN_W+1:0]  mant;
  logic              guard, sticky, lost, inc, ovf, big;
  logic [ENC_W-1:0]  enc;
  logic [H_W-1:0]    d_n;
  logic [FLG_W-1:0]  f_n;

  always_comb begin
    msb = 0;
    for (int i = 0; i < FIX_W; i++) if (s2_i.mag[i]) msb = i;
    lsb    = (msb >= SUB_LSB + MAN_W) ? msb - MAN_W : SUB_LSB;
    mant   = (MAN_W+2)'(s2_i.mag >> lsb);
    guard  = s2_i.mag[lsb-1];
    sticky = |(s2_i.mag & ((FIX_W'(1) << (lsb - 1)) - FIX_W'(1)));
    lost   = guard | sticky;
    case (s2_i.rm)
      RM_RNE:  inc = guard & (sticky | mant[0]);
      RM_RUP:  inc = !s2_i.sign & lost;
      RM_RDN:  inc = s2_i.sign & lost;
      default: inc = 1'b0;
    endcase
    // exponent field rides on the carry out of the significand
    enc = (ENC_W'(lsb - SUB_LSB) << MAN_W) + ENC_W'(mant) + ENC_W'(inc);
    ovf = enc >= ENC_W'(INF_MAG);
    big = (s2_i.rm == RM_RNE) || (s2_i.rm == RM_RUP && !s2_i.sign)
       || (s2_i.rm == RM_RDN && s2_i.sign);

    d_n = {s2_i.sign, enc[H_W-2:0]};
    f_n = {3'b000, lost & (enc < ENC_W'(1 << MAN_W)), lost};
    if (ovf) begin
      d_n = {s2_i.sign, big ? INF_MAG : INF_MAG - 1'b1};
      f_n = 5'b00101;
    end
    if (s2_i.res_inf) begin
      d_n = {s2_i.inf_sign, INF_MAG};
      f_n = '0;
    end
    if (s2_i.res_nan) begin
      d_n = QNAN_H;
      f_n = {s2_i.invalid, 4'b0000};
    end
    if (s2_i.quiet) f_n = '0;
    if (!s2_i.pred) begin
      d_n = s2_i.c_raw;
      f_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      d_o     <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= s2_i.valid;
      d_o     <= d_n;
      flags_o <= f_n;
    end
  end

  p_quiet_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_i.valid && s2_i.quiet) |=> (flags_o == '0));

  p_pred_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_i.valid && !s2_i.pred) |=> (d_o == $past(s2_i.c_raw) && flags_o == '0));

  p_nan_canon_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_i.valid && s2_i.pred && s2_i.res_nan) |=> (d_o == QNAN_H));

  p_ovf_inexact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[2]) |-> flags_o[0]);

  p_unf_tiny_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[1]) |-> (flags_o[0] && d_o[H_W-2:MAN_W] == '0));
endmodule

// File: rtl/fma16_pipe.sv
module fma16_pipe
  import fma16_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic [15:0] c_i,
  input  logic [1:0]  rm_i,
  input  logic [2:0]  op_i,
  input  logic        pred_i,
  output logic        valid_o,
  output logic [15:0] d_o,
  output logic [4:0]  flags_o
);
  s1_t s1_q;
  s2_t s2_q;

  fma16_mul_stage u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .rm_i(rm_i), .op_i(op_i),
    .pred_i(pred_i), .s1_o(s1_q)
  );

  fma16_add_stage u_add (
    .clk_i(clk_i), .rst_ni(rst_ni), .s1_i(s1_q), .s2_o(s2_q)
  );

  fma16_round_stage u_rnd (
    .clk_i(clk_i), .rst_ni(rst_ni), .s2_i(s2_q),
    .valid_o(valid_o), .d_o(d_o), .flags_o(flags_o)
  );
endmodule

// File: tb/fma16_pipe_tb_top.sv
module fma16_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0, c_i = '0;
  logic [1:0]  rm_i = '0;
  logic [2:0]  op_i = '0;
  logic        pred_i = 1'b1;
  logic        valid_o;
  logic [15:0] d_o;
  logic [4:0]  flags_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  typedef struct { logic [15:0] d; logic [4:0] f; int cyc; string tag; } exp_t;
  exp_t q[$];

  fma16_pipe dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .c_i(c_i), .rm_i(rm_i), .op_i(op_i), .pred_i(pred_i),
    .valid_o(valid_o), .d_o(d_o), .flags_o(flags_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ---- behavioural reference: exact integers, rounding by code search ----
  function automatic logic [127:0] hval(input logic [14:0] m); // |x| * 2^48
    int ee = (m[14:10] != 0) ? int'(m[14:10]) : 1;
    logic [127:0] s = {117'd0, (m[14:10] != 0), m[9:0]};
    return s << (ee + 23);
  endfunction

  function automatic bit is_nan(input logic [15:0] x);
    return x[14:10] == 5'h1f && x[9:0] != 0;
  endfunction
  function automatic bit is_inf(input logic [15:0] x);
    return x[14:0] == 15'h7c00;
  endfunction

  function automatic logic [20:0] model(input logic [15:0] a, b, c,
                                        input logic [1:0] rm, input logic [2:0] op);
    logic [15:0] be, ce;
    logic sp, sc, sg;
    logic signed [127:0] x, pv, cv;
    logic [127:0] mag, vl, vu, dl, du;
    int lo, hi, mid, code;
    bit nx, big;
    logic [4:0] f;
    logic [15:0] d;
    be = (op == 3'd0) ? 16'h3c00 : b;
    sp = a[15] ^ be[15] ^ (op == 3'd5);
    case (op)
      3'd1: ce = {sp, 15'd0};
      3'd5: ce = 16'h3c00;
      3'd3: ce = {~c[15], c[14:0]};
      default: ce = c;
    endcase
    sc = ce[15];
    f = 5'd0;
    if (is_nan(a) || is_nan(be) || is_nan(ce)) begin
      d = 16'h7e00;
      f[4] = (is_nan(a) && !a[9]) || (is_nan(be) && !be[9]) || (is_nan(ce) && !ce[9]);
    end else if ((is_inf(a) && be[14:0] == 0) || (a[14:0] == 0 && is_inf(be))) begin
      d = 16'h7e00; f = 5'b10000;
    end else if ((is_inf(a) || is_inf(be)) && is_inf(ce) && sp != sc) begin
      d = 16'h7e00; f = 5'b10000;
    end else if (is_inf(a) || is_inf(be)) begin
      d = {sp, 15'h7c00};
    end else if (is_inf(ce)) begin
      d = {sc, 15'h7c00};
    end else begin
      pv = $signed((hval(a[14:0]) >> 24) * (hval(be[14:0]) >> 24));
      cv = $signed(hval(ce[14:0]));
      x = (sp ? -pv : pv) + (sc ? -cv : cv);
      if (x == 0) begin
        d = {((sp == sc) ? sp : (rm == 2'd3)), 15'd0};
      end else begin
        sg = x < 0;
        mag = sg ? 128'(-x) : 128'(x);
        lo = 0; hi = 32'h7c00;
        while (lo < hi) begin
          mid = (lo + hi + 1) / 2;
          if (hval(15'(mid)) <= mag) lo = mid; else hi = mid - 1;
        end
        if (lo >= 32'h7c00) code = lo;
        else begin
          vl = hval(15'(lo)); vu = hval(15'(lo + 1));
          nx = (mag != vl);
          dl = mag - vl; du = vu - mag;
          code = lo;
          if (nx) case (rm)
            2'd0: code = (dl < du) ? lo : (du < dl) ? lo + 1 : (lo % 2 == 1) ? lo + 1 : lo;
            2'd2: code = sg ? lo : lo + 1;
            2'd3: code = sg ? lo + 1 : lo;
            default: code = lo;
          endcase
        end
        if (code >= 32'h7c00) begin
          big = (rm == 2'd0) || (rm == 2'd2 && !sg) || (rm == 2'd3 && sg);
          d = {sg, big ? 15'h7c00 : 15'h7bff};
          f = 5'b00101;
        end else begin
          d = {sg, 15'(code)};
          f = {3'b000, nx && code < 32'h400, nx};
        end
      end
    end
    if (op == 3'd4) f = 5'd0;
    return {d, f};
  endfunction

  // ---- checking at the falling edge ----
  task automatic check_out();
    exp_t e;
    if (valid_o) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1: valid_o=1 expected 0 (no outstanding op)");
      end else begin
        e = q.pop_front();
        n_chk++;
        if (d_o !== e.d || flags_o !== e.f || cyc - e.cyc != 3) begin
          n_fail++;
          $display("FAIL %s: d=%h flags=%b lat=%0d expected d=%h flags=%b lat=3",
                   e.tag, d_o, flags_o, cyc - e.cyc, e.d, e.f);
        end
      end
    end else if (q.size() != 0 && cyc - q[0].cyc >= 3) begin
      n_chk++; n_fail++;
      $display("FAIL R1: valid_o=0 expected 1 for op issued at %0d", q[0].cyc);
      void'(q.pop_front());
    end
  endtask

  task automatic apply(input logic [15:0] a, b, c, input logic [1:0] rm,
                       input logic [2:0] op, input logic p, input string tag,
                       input bit lit = 0, input logic [15:0] ed = 0, input logic [4:0] ef = 0);
    exp_t e;
    logic [20:0] r;
    @(negedge clk);
    check_out();
    valid_i = 1'b1; a_i = a; b_i = b; c_i = c; rm_i = rm; op_i = op; pred_i = p;
    r = model(a, b, c, rm, op);
    e.d = r[20:5]; e.f = r[4:0];
    if (lit) begin e.d = ed; e.f = ef; end
    if (!p) begin e.d = c; e.f = 5'd0; end
    e.cyc = cyc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_out();
      valid_i = 1'b0;
    end
  endtask

  function automatic logic [15:0] rand_h();
    int k = $urandom % 16;
    logic [15:0] sp_list [8] = '{16'h0000, 16'h8000, 16'h7c00, 16'hfc00,
                                 16'h7e00, 16'h7c01, 16'h0001, 16'h7bff};
    if (k == 0) return sp_list[$urandom % 8];
    if (k < 3)  return {1'($urandom), 5'd0, 10'($urandom)};
    if (k < 5)  return {1'($urandom), 5'(27 + $urandom % 4), 10'($urandom)};
    return {1'($urandom), 5'(1 + $urandom % 30), 10'($urandom)};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1: watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0 || d_o !== 16'h0 || flags_o !== 5'h0) begin
      n_fail++;
      $display("FAIL R1: reset state valid=%b d=%h flags=%b expected 0 0 0", valid_o, d_o, flags_o);
    end
    rst_ni = 1'b1;
    idle(2);

    // R3 tie 1.0 + 2^-11 under each mode
    apply(16'h3c00, 16'h0, 16'h1000, 2'd0, 3'd0, 1, "R3 rne", 1, 16'h3c00, 5'b00001);
    apply(16'h3c00, 16'h0, 16'h1000, 2'd1, 3'd0, 1, "R3 rtz", 1, 16'h3c00, 5'b00001);
    apply(16'h3c00, 16'h0, 16'h1000, 2'd2, 3'd0, 1, "R3 rup", 1, 16'h3c01, 5'b00001);
    apply(16'h3c00, 16'h0, 16'h1000, 2'd3, 3'd0, 1, "R3 rdn", 1, 16'h3c00, 5'b00001);
    // R6 specials
    apply(16'h7c00, 16'h0, 16'hfc00, 2'd0, 3'd0, 1, "R6 inf-inf", 1, 16'h7e00, 5'b10000);
    apply(16'h7c00, 16'h0000, 16'h0, 2'd0, 3'd1, 1, "R6 inf*0", 1, 16'h7e00, 5'b10000);
    apply(16'h7c01, 16'h3c00, 16'h0, 2'd0, 3'd2, 1, "R6 snan", 1, 16'h7e00, 5'b10000);
    apply(16'h7e01, 16'h3c00, 16'h0, 2'd0, 3'd2, 1, "R6 qnan", 1, 16'h7e00, 5'b00000);
    // R7 overflow per mode
    apply(16'h7bff, 16'h0, 16'h7bff, 2'd0, 3'd0, 1, "R7 rne", 1, 16'h7c00, 5'b00101);
    apply(16'h7bff, 16'h0, 16'h7bff, 2'd1, 3'd0, 1, "R7 rtz", 1, 16'h7bff, 5'b00101);
    apply(16'h7bff, 16'h0, 16'h7bff, 2'd3, 3'd0, 1, "R7 rdn", 1, 16'h7bff, 5'b00101);
    apply(16'hfbff, 16'h0, 16'hfbff, 2'd3, 3'd0, 1, "R7 rdn neg", 1, 16'hfc00, 5'b00101);
    // R8 inexact only, and an exact sum
    apply(16'h3c00, 16'h0, 16'h0001, 2'd0, 3'd0, 1, "R8 tiny", 1, 16'h3c00, 5'b00001);
    apply(16'h3c00, 16'h0, 16'h3c00, 2'd0, 3'd0, 1, "R8 exact", 1, 16'h4000, 5'b00000);
    // R2 single rounding
    apply(16'h3c01, 16'h3c01, 16'hbc02, 2'd0, 3'd2, 1, "R2 fused", 1, 16'h0010, 5'b00000);
    // R4 op classes
    apply(16'h4000, 16'h4000, 16'h3c00, 2'd0, 3'd3, 1, "R4 msub", 1, 16'h4200, 5'b00000);
    apply(16'h3c00, 16'h7e00, 16'h3c00, 2'd0, 3'd0, 1, "R4 add ignores b", 1, 16'h4000, 5'b00000);
    apply(16'h4000, 16'h4000, 16'h7c00, 2'd0, 3'd1, 1, "R4 mul ignores c", 1, 16'h4400, 5'b00000);
    // R5 residual
    apply(16'h3800, 16'h3800, 16'h1234, 2'd0, 3'd5, 1, "R5 resid", 1, 16'h3a00, 5'b00000);
    apply(16'h4000, 16'h3800, 16'h1234, 2'd0, 3'd5, 1, "R5 resid zero", 1, 16'h0000, 5'b00000);
    // R9 subnormals
    apply(16'h0001, 16'h3800, 16'h0, 2'd0, 3'd1, 1, "R9 to zero", 1, 16'h0000, 5'b00011);
    apply(16'h0200, 16'h3c00, 16'h0, 2'd0, 3'd1, 1, "R9 exact sub", 1, 16'h0200, 5'b00000);
    apply(16'h0400, 16'h3bff, 16'h0, 2'd0, 3'd1, 1, "R9 round to normal", 1, 16'h0400, 5'b00001);
    // R10 quiet class
    apply(16'h7bff, 16'h4000, 16'h0000, 2'd0, 3'd4, 1, "R10 quiet ovf", 1, 16'h7c00, 5'b00000);
    // R11 predicate off
    apply(16'h3c00, 16'h3c00, 16'h1234, 2'd0, 3'd2, 0, "R11 pred off", 1, 16'h1234, 5'b00000);
    apply(16'h7c00, 16'h0000, 16'hfe55, 2'd0, 3'd2, 0, "R11 pred off nan c", 1, 16'hfe55, 5'b00000);
    // R13 zero signs
    apply(16'h8000, 16'h3c00, 16'h0, 2'd0, 3'd1, 1, "R13 neg zero mul", 1, 16'h8000, 5'b00000);
    apply(16'h3c00, 16'h3c00, 16'hbc00, 2'd3, 3'd2, 1, "R13 cancel rdn", 1, 16'h8000, 5'b00000);
    apply(16'h3c00, 16'h3c00, 16'hbc00, 2'd0, 3'd2, 1, "R13 cancel rne", 1, 16'h0000, 5'b00000);
    idle(2);
    // R12 random stream: flags order and divide-by-zero stay per the model
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] ra, rb, rc;
      ra = rand_h(); rb = rand_h(); rc = rand_h();
      if (i % 7 == 0) rc = {~ra[15], ra[14:0]};
      apply(ra, rb, rc, 2'($urandom), 3'($urandom % 6), ($urandom % 8) != 0, "R12 random");
      if (i % 97 == 0) idle(1);
    end
    idle(6);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1: %0d results missing expected 0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule